// File: doc/BRIEF.md
# Time Base Interval Timer

A free-running 20-bit counter advances by one on every clock. Software picks one of eight counter taps through a 3-bit select field. Each time the picked tap falls from 1 to 0, the block sets a sticky interval flag. An interrupt line carries that flag gated by an enable bit. Software uses the block as a periodic tick source: it sets the interval and the enable, then writes 0 to the flag from its handler.

All of this sits in one 16-bit control word reached over a simple register bus. The bus has an address, write data, a write strobe, a read strobe and a read-modify-write qualifier. Reads are combinational with no wait states. While the qualifier is high, a read returns the flag as 1, so a bit-set or bit-clear on another field writes back a 1 and cannot clear a pending flag. The same word holds two stop-mode oscillator-off controls, which drive a clock controller. It also holds two option bits that are kept as plain storage. All pins are plain control and status lines, and none of them uses a handshake.

Top module: `tbt_top`

## Requirements
- R1: After reset the word reads 0x0003: flag, enable, select and option bits are 0, and both oscillator-off bits are 1. `irq` is 0, and `osc_stop_sub` and `osc_stop_main` are 1.
- R2: The counter starts at 0 after reset and counts up by one each clock. The flag (bit 15) becomes 1 right after the clock edge at which the count since reset reaches a multiple of 2^(13+S), where S is the select code. That is the edge at which counter bit 12+S falls.
- R3: Changing the select does not clear the counter. The next flag comes at the next multiple of the new interval, counted from reset.
- R4: Writing 0 to bit 15 clears the flag. Writing 1 to bit 15 leaves the flag as it was, whether it is 0 or 1.
- R5: If a flag-setting edge and a write of 0 to bit 15 fall in the same cycle, the flag ends up 1.
- R6: A read with `bus_rmw` high returns 1 in bit 15. A plain read returns the true flag.
- R7: `irq` is 1 exactly when the flag is 1 and the enable (bit 14) is 1.
- R8: The fields are read/write: select in bits 13:11, option bits in 9:8, sub-oscillator-off in bit 1 (drives `osc_stop_sub`), main-oscillator-off in bit 0 (drives `osc_stop_main`). All other bits read as 0.
- R9: `bus_rdata` is 0 unless `bus_re` is high and `bus_addr` equals the register address (default 0). Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counter's count input |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_re | input | 1 | Read strobe, combinational data |
| bus_rmw | input | 1 | Marks a read as part of a read-modify-write |
| bus_rdata | output | 16 | Read data |
| irq | output | 1 | Interval interrupt request |
| osc_stop_sub | output | 1 | Sub oscillator stops in stop mode when 1 |
| osc_stop_main | output | 1 | Main oscillator stops in stop mode when 1 |

## Verification
The bench samples the flag at three select codes and checks the exact edge count since reset at which it rises. A wrong tap or an off-by-one edge shows up as a different count. The select is changed in mid-run and the bench checks that the next event lands on the absolute multiple, not a full interval after the change, which tells a running counter apart from one that restarts. A clear write placed on the very edge of an event separates set-priority from clear-priority. Plain and read-modify-write reads with the flag at 0 tell the masking read apart from a true read.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int DATA_W    = 16;
  localparam int B_FLAG    = 15;
  localparam int B_IE      = 14;
  localparam int B_SEL_HI  = 13;
  localparam int B_SEL_LO  = 11;
  localparam int B_OPT_HI  = 9;
  localparam int B_OPT_LO  = 8;
  localparam int B_OSC_SUB = 1;
  localparam int B_OSC_MAIN = 0;
  localparam int SEL_W     = B_SEL_HI - B_SEL_LO + 1;
  localparam int OPT_W     = B_OPT_HI - B_OPT_LO + 1;

  typedef struct packed {
    logic             flag;
    logic             ie;
    logic [SEL_W-1:0] sel;
    logic [OPT_W-1:0] opt;
    logic             osc_sub;
    logic             osc_main;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{flag: 1'b0, ie: 1'b0, sel: '0, opt: '0,
                                   osc_sub: 1'b1, osc_main: 1'b1};

  function automatic logic [DATA_W-1:0] pack_word(ctrl_t c, logic force_flag);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_FLAG]              = c.flag | force_flag;
    w[B_IE]                = c.ie;
    w[B_SEL_HI:B_SEL_LO]   = c.sel;
    w[B_OPT_HI:B_OPT_LO]   = c.opt;
    w[B_OSC_SUB]           = c.osc_sub;
    w[B_OSC_MAIN]          = c.osc_main;
    return w;
  endfunction
endpackage

// File: rtl/tbt_timebase.sv
module tbt_timebase #(
  parameter int CNT_W    = 20,
  parameter int TAP_BASE = 12,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int TAP_MAX = TAP_BASE + (1 << SEL_W) - 1;

  initial begin
    if (TAP_MAX >= CNT_W) $error("tap range exceeds counter width");
  end

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] low_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  // Selected tap falls on the next edge when it and every bit below it are 1.
  always_comb begin
    for (int i = 0; i < CNT_W; i++)
      low_mask[i] = (i <= TAP_BASE + int'(sel));
  end

  assign tick = &(cnt | ~low_mask);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/tbt_ctrl_reg.sv
module tbt_ctrl_reg
  import tbt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_rmw,
  input  logic              tick,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [SEL_W-1:0]  sel,
  output logic              irq,
  output logic              osc_stop_sub,
  output logic              osc_stop_main
);
  ctrl_t q;
  logic  hit;
  logic  wr_hit;

  assign hit    = (bus_addr == ADDR_W'(REG_ADDR));
  assign wr_hit = bus_we && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= CTRL_RESET;
    end else begin
      if (tick)
        q.flag <= 1'b1;
      else if (wr_hit && !bus_wdata[B_FLAG])
        q.flag <= 1'b0;
      if (wr_hit) begin
        q.ie       <= bus_wdata[B_IE];
        q.sel      <= bus_wdata[B_SEL_HI:B_SEL_LO];
        q.opt      <= bus_wdata[B_OPT_HI:B_OPT_LO];
        q.osc_sub  <= bus_wdata[B_OSC_SUB];
        q.osc_main <= bus_wdata[B_OSC_MAIN];
      end
    end
  end

  assign bus_rdata     = (bus_re && hit) ? pack_word(q, bus_rmw) : '0;
  assign sel           = q.sel;
  assign irq           = q.flag & q.ie;
  assign osc_stop_sub  = q.osc_sub;
  assign osc_stop_main = q.osc_main;

  p_flag_rise_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q.flag) |-> $past(tick));

  p_set_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> q.flag);

  p_zero_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !bus_wdata[B_FLAG] && !tick) |=> !q.flag);

  p_one_write_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q.flag && wr_hit && bus_wdata[B_FLAG]) |=> q.flag);
endmodule

// File: rtl/tbt_top.sv
module tbt_top
  import tbt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0,
  parameter int CNT_W    = 20,
  parameter int TAP_BASE = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_rmw,
  output logic [15:0]       bus_rdata,
  output logic              irq,
  output logic              osc_stop_sub,
  output logic              osc_stop_main
);
  logic [SEL_W-1:0] sel;
  logic             tick;

  tbt_timebase #(.CNT_W(CNT_W), .TAP_BASE(TAP_BASE), .SEL_W(SEL_W)) u_timebase (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (sel),
    .tick (tick)
  );

  tbt_ctrl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_we       (bus_we),
    .bus_re       (bus_re),
    .bus_rmw      (bus_rmw),
    .tick         (tick),
    .bus_rdata    (bus_rdata),
    .sel          (sel),
    .irq          (irq),
    .osc_stop_sub (osc_stop_sub),
    .osc_stop_main(osc_stop_main)
  );
endmodule

// File: tb/test_tbt_top.sv
module test_tbt_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic        bus_rmw = 1'b0;
  logic [15:0] bus_rdata;
  logic        irq, osc_stop_sub, osc_stop_main;

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  tbt_top i_tbt_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rmw(bus_rmw), .bus_rdata(bus_rdata),
    .irq(irq), .osc_stop_sub(osc_stop_sub), .osc_stop_main(osc_stop_main)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, logic rmw, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rmw = rmw; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0; bus_rmw = 1'b0;
  endtask

  task automatic wait_flag(int limit, output int seen);
    logic [15:0] d;
    seen = -1;
    for (int i = 0; i < limit; i++) begin
      bus_read(4'h0, 1'b0, d);
      if (d[15]) begin seen = ecount; return; end
    end
  endtask

  task automatic t_reset;
    logic [15:0] d;
    bus_read(4'h0, 1'b0, d);
    check("R1 word", d, 16'h0003);
    check("R1 irq", irq, 0);
    check("R1 osc_stop_sub", osc_stop_sub, 1);
    check("R1 osc_stop_main", osc_stop_main, 1);
  endtask

  task automatic t_fields;
    logic [15:0] d;
    bus_write(4'h0, 16'hFFFF);
    bus_read(4'h0, 1'b0, d);
    check("R8 all fields set, R4 one does not set flag", d, 16'h7B03);
    bus_write(4'h0, 16'h0000);
    bus_read(4'h0, 1'b0, d);
    check("R8 all fields clear", d, 16'h0000);
    check("R8 osc_stop_sub follows bit1", osc_stop_sub, 0);
    check("R8 osc_stop_main follows bit0", osc_stop_main, 0);
    bus_write(4'h0, 16'h0302);
    bus_read(4'h1, 1'b0, d);
    check("R9 other address reads 0", d, 0);
    bus_write(4'h1, 16'h0001);
    bus_read(4'h0, 1'b0, d);
    check("R9 other address write ignored", d, 16'h0302);
    @(negedge clk);
    bus_addr = 4'h0;
    #1 check("R9 no strobe reads 0", bus_rdata, 0);
    bus_write(4'h0, 16'h0003);
  endtask

  task automatic t_interval0;
    int seen;
    logic [15:0] d;
    wait_flag(20000, seen);
    check("R2 sel0 event edge", seen, 8192);
    check("R7 irq low with enable 0", irq, 0);
    bus_write(4'h0, 16'hC003);
    check("R7 irq high with flag and enable", irq, 1);
    bus_read(4'h0, 1'b0, d);
    check("R4 write 1 keeps flag", d[15], 1);
    bus_write(4'h0, 16'h4003);
    bus_read(4'h0, 1'b0, d);
    check("R4 write 0 clears flag", d[15], 0);
    check("R7 irq low after clear", irq, 0);
  endtask

  task automatic t_rmw;
    logic [15:0] d;
    bus_read(4'h0, 1'b0, d);
    check("R6 plain read shows real flag", d, 16'h4003);
    bus_read(4'h0, 1'b1, d);
    check("R6 rmw read forces flag", d, 16'hC003);
  endtask

  task automatic t_select_change;
    int seen;
    bus_write(4'h0, 16'h0803);
    wait_flag(30000, seen);
    check("R3 sel change keeps counter", seen, 16384);
    bus_write(4'h0, 16'h1003);
    wait_flag(40000, seen);
    check("R2 sel2 event edge", seen, 32768);
    bus_write(4'h0, 16'h0003);
  endtask

  task automatic t_set_wins;
    logic [15:0] d;
    while (ecount != 40959) @(negedge clk);
    bus_addr = 4'h0; bus_wdata = 16'h0003; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    bus_read(4'h0, 1'b0, d);
    check("R5 set wins over clear", d[15], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_interval0();
    t_rmw();
    t_select_change();
    t_set_wins();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule